// File: doc/BRIEF.md
# Maximal-Length Shift Counter with Optional All-Zero State

This block is a synchronous counter built from an N-bit shift register whose top stage is fed by a parity of selected stages. The width is a parameter from 2 to 16. For each width a fixed table supplies the feedback taps. Each entry is chosen so that the plain counter walks through every nonzero N-bit value once before it repeats, a cycle of 2^N−1 steps. Counters of this kind are used as cheap dividers, test-pattern sources and state sequencers. Only a few gates sit between stages, so they reach high clock rates at any width.

A second parameter turns on a correction term that splices the all-zero value into the cycle. The sequence then covers all 2^N values. The correction inverts the feedback bit whenever every stage except bit 0 reads zero. This sends the seed value 0…01 to zero, and sends zero to 10…0, which is where the seed would otherwise have gone.

Each clock edge applies one of three operations. `OP_SEED` is chosen when reset is high and loads 0…01. `OP_SHIFT` is chosen when enable is high and reset is low, and takes one step. `OP_HOLD` is chosen when both are low and keeps the value. The output is the register itself.

Top module: `lfsr_zcounter`

## Requirements
- R1: With the correction off, starting from the seed 0…01 (bit 0 = 1), the counter returns to the seed after exactly 2^WIDTH−1 enabled steps, for every WIDTH from 2 to 16. The feedback is the XOR of the stages X_i picked by the width's tap table, where X0 is bit 0. The table is: 2: X0,X1; 3: X0,X1; 4: X0,X1; 5: X0,X2; 6: X0,X1; 7: X0,X3; 8: X0,X2,X3,X4; 9: X0,X4; 10: X0,X3; 11: X0,X2; 12: X0,X1,X4,X6; 13: X0,X1,X3,X4; 14: X0,X1,X6,X10; 15: X0,X1; 16: X0,X3,X4,X5.
- R2: Reset is synchronous and takes priority over enable. At the edge after reset is sampled high, the state is 0…01.
- R3: When enable is low and reset is low, the state does not change at the clock edge.
- R4: On an enabled step, bit i takes the old value of bit i+1 for every i below WIDTH−1. The top bit receives the feedback bit.
- R5: With the correction off, the state is never all-zero after reset.
- R6: With the correction on, an enabled step from 0…01 gives all-zero, and an enabled step from all-zero gives a value with only the top bit set.
- R7: With the correction on, the counter returns to the seed after exactly 2^WIDTH enabled steps and passes through all-zero exactly once in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads the seed |
| en | input | 1 | Step enable, active high |
| state | output | WIDTH | Current counter value |

## Verification
The output is the register itself, so a wrong next-state value shows at the ports one edge after it happens. A fault in the shift path breaks the bit-by-bit relation between consecutive samples on that step. A wrong tap does not show at once. It appears as a cycle that returns to the seed too early, or never returns, within the 2^WIDTH window. This is why every width from 2 to 16 is run over a full cycle, with and without the zero correction, while enable is dropped every eighth cycle. A misplaced zero splice shows as a missing or repeated all-zero value, or as a wrong successor to zero.

// File: rtl/lfsr_zcounter_pkg.sv
package lfsr_zcounter_pkg;

    localparam int MIN_WIDTH = 2;
    localparam int MAX_WIDTH = 16;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_SEED  = 2'd2
    } lfsr_op_e;

    // Bit i set: stage X_i joins the parity that feeds the top stage.
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
        logic [MAX_WIDTH-1:0] m;
        case (width)
            2:       m = 16'h0003;
            3:       m = 16'h0003;
            4:       m = 16'h0003;
            5:       m = 16'h0005;
            6:       m = 16'h0003;
            7:       m = 16'h0009;
            8:       m = 16'h001D;
            9:       m = 16'h0011;
            10:      m = 16'h0009;
            11:      m = 16'h0005;
            12:      m = 16'h0053;
            13:      m = 16'h001B;
            14:      m = 16'h0443;
            15:      m = 16'h0003;
            16:      m = 16'h0039;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsrz_parity.sv
module lfsrz_parity #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    TAPS = {W{1'b1}}
) (
    input  logic [W-1:0] stages,
    output logic         fb
);
    logic [W-1:0] picked;

    for (genvar i = 0; i < W; i++) begin : g_pick
        if (TAPS[i]) begin : g_on
            assign picked[i] = stages[i];
        end else begin : g_off
            assign picked[i] = 1'b0;
        end
    end

    assign fb = ^picked;
endmodule

// File: rtl/lfsrz_zero_fix.sv
module lfsrz_zero_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] stages,
    output logic         flip
);
    // All stages that remain after the shift are zero.
    assign flip = ~|stages[W-1:1];
endmodule

// File: rtl/lfsr_zcounter.sv
module lfsr_zcounter
    import lfsr_zcounter_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit ZERO_STATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] state
);
    localparam logic [MAX_WIDTH-1:0] TAP_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]     TAPS     = TAP_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0]     SEED     = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0]     TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    lfsr_op_e         op;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt;
    logic             fb_lin;
    logic             fb_fix;

    lfsrz_parity #(.W(WIDTH), .TAPS(TAPS)) u_parity (
        .stages (cur_q),
        .fb     (fb_lin)
    );

    if (ZERO_STATE) begin : g_zero
        lfsrz_zero_fix #(.W(WIDTH)) u_zero_fix (
            .stages (cur_q),
            .flip   (fb_fix)
        );
    end else begin : g_plain
        assign fb_fix = 1'b0;
    end

    always_comb begin
        if (rst)     op = OP_SEED;
        else if (en) op = OP_SHIFT;
        else         op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_SEED:  nxt = SEED;
            OP_SHIFT: nxt = {fb_lin ^ fb_fix, cur_q[WIDTH-1:1]};
            OP_HOLD:  nxt = cur_q;
            default:  nxt = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt;
    end

    always_comb begin
        state = cur_q;
    end

    AST_SEED_LOAD: assert property (@(posedge clk)
        rst |=> state == SEED);                                          // R2
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));                                         // R3
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        en |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));             // R4

    if (ZERO_STATE) begin : g_zero_chk
        AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
            (en && state == SEED) |=> state == '0);                      // R6
        AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (rst)
            (en && state == '0) |=> state == TOP_ONLY);                  // R6
    end else begin : g_plain_chk
        AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> state != '0);                                // R5
    end
endmodule

// File: tb/lfsr_zcounter_bench.sv
module lfsr_zcounter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 76000;
    localparam int WATCHDOG   = 120000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic rst_q = 1'b1;
    logic en_q  = 1'b0;
    bit   running  = 1'b0;
    bit   final_chk = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;

    logic [15:0] q_all   [2:16][0:1];
    logic [15:0] prev_s  [2:16][0:1];
    int          steps_s [2:16][0:1];
    int          zeros_s [2:16][0:1];
    bit          done_s  [2:16][0:1];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar gw = 2; gw <= 16; gw++) begin : g_w
        for (genvar gz = 0; gz < 2; gz++) begin : g_z
            logic [gw-1:0] q;
            lfsr_zcounter #(.WIDTH(gw), .ZERO_STATE(gz[0])) u_lfsr_zcounter (
                .clk   (clk),
                .rst   (rst),
                .en    (en),
                .state (q)
            );
            assign q_all[gw][gz] = 16'(q);
        end
    end

    always @(posedge clk) begin
        rst_q <= rst;
        en_q  <= en;
    end

    task automatic chk(input bit ok, input string req, input int w, input int z,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s width=%0d zero=%0d actual=%0h expected=%0h",
                     req, w, z, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            for (int w = 2; w <= 16; w++) begin
                for (int z = 0; z < 2; z++) begin
                    logic [15:0] cur;
                    logic [15:0] pv;
                    logic [15:0] low_mask;
                    int          period;
                    cur      = q_all[w][z];
                    pv       = prev_s[w][z];
                    low_mask = 16'((32'd1 << (w - 1)) - 1);
                    period   = (z == 1) ? (1 << w) : ((1 << w) - 1);
                    if (rst_q) begin
                        // R2: seed value 0...01 after reset, enable high or low
                        chk(cur == 16'd1, "R2", w, z, cur, 1);
                    end else if (!en_q) begin
                        // R3: disabled edge keeps the value
                        chk(cur == pv, "R3", w, z, cur, pv);
                    end else begin
                        // R4: lower bits take the old value one place up
                        chk((cur & low_mask) == ((pv >> 1) & low_mask), "R4", w, z,
                            cur & low_mask, (pv >> 1) & low_mask);
                        if (z == 0) begin
                            chk(cur != 16'd0, "R5", w, z, cur, 1);
                        end else if (pv == 16'd1) begin
                            chk(cur == 16'd0, "R6", w, z, cur, 0);
                        end else if (pv == 16'd0) begin
                            chk(cur == 16'(32'd1 << (w - 1)), "R6", w, z, cur,
                                1 << (w - 1));
                        end
                        if (!done_s[w][z]) begin
                            steps_s[w][z]++;
                            if (cur == 16'd0) zeros_s[w][z]++;
                            if (cur == 16'd1) begin
                                done_s[w][z] = 1'b1;
                                // R1 (tap table, plain) and R7 (zero spliced) cycle length
                                chk(steps_s[w][z] == period, z ? "R7" : "R1", w, z,
                                    steps_s[w][z], period);
                            end
                        end
                    end
                    prev_s[w][z] = cur;
                    if (final_chk) begin
                        chk(done_s[w][z], z ? "R7" : "R1", w, z,
                            int'(done_s[w][z]), 1);
                        chk(zeros_s[w][z] == z, z ? "R7" : "R5", w, z,
                            zeros_s[w][z], z);
                    end
                end
            end
        end
    end

    initial begin
        for (int w = 2; w <= 16; w++) begin
            for (int z = 0; z < 2; z++) begin
                prev_s[w][z]  = 16'd1;
                steps_s[w][z] = 0;
                zeros_s[w][z] = 0;
                done_s[w][z]  = 1'b0;
            end
        end
    end

    initial begin
        rst = 1'b1;
        en  = 1'b1;
        repeat (2) @(posedge clk);
        running = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            en = ((c % 8) != 7);
        end
        @(negedge clk);
        en  = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        @(posedge clk);
        final_chk = 1'b1;
        @(posedge clk);
        final_chk = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_errors + 1);
        $finish;
    end
endmodule